// File: doc/BRIEF.md
# Communication Watchdog With Pause Input

This block sits between the host command path and the gating that enables the cell balancers. It stops balancing if the host goes quiet and lets an external driver pause balancing. When a balance command begins executing, a cycle timer starts. Every valid command byte clears it. A valid byte is an execute, a write, or a read of command or status, including a partial transfer whose first eight bits carried the correct address. If the timer reaches its limit without a valid byte, the block times out. In that state the permit output falls and the status pin is released high. The stored command is not touched here. Once timed out, only an execute command brings balancing back.

The status output models the level on an open-drain, wired pin. The block pulls the pin low while balancing is in progress and releases it otherwise. An external driver can force the same pin high. That high is also the pause request, and it is honoured only while the timer has not expired. A power-on reset returns the block to idle with no permit. A defeat strap stops any timeout from occurring.

Top module: `cwd_watchdog`

## Requirements
- R1: While `rst_n` is low and just after it rises, the block is idle: `run_ok` is 0 and `wdt_pin` is 1.
- R2: In idle, a `bal_start` pulse makes `run_ok` 1 and `wdt_pin` 0 from the next cycle on, provided `pause_in` is 0.
- R3: If neither `byte_valid` nor `exec_cmd` is seen for TIMEOUT_CYC consecutive active cycles, the block times out. Active cycles are running or paused cycles. Counting starts from the cycle in which the block entered running or last saw a clear. After the timeout, `run_ok` is 0 and `wdt_pin` is 1.
- R4: A cycle with `byte_valid` or `exec_cmd` high restarts the count. A steady stream of such bytes, spaced less than TIMEOUT_CYC cycles apart, keeps balancing permitted indefinitely.
- R5: Once timed out, `byte_valid`, `bal_start` and idle cycles leave `run_ok` at 0. An `exec_cmd` pulse makes `run_ok` 1 from the next cycle, with a fresh count.
- R6: While not timed out, `pause_in` high forces `run_ok` to 0 in the same cycle, and `wdt_pin` reads 1. After `pause_in` falls, `run_ok` returns to 1 one cycle later.
- R7: The count keeps running during a pause, so a long pause can end in a timeout. In the timed-out state, raising and releasing `pause_in` does not restore `run_ok`.
- R8: While `defeat` is 1, no timeout occurs however long the quiet gap. If `defeat` falls after a gap of at least TIMEOUT_CYC-1 quiet cycles, the timeout is taken at the next clock edge.
- R9: In idle, `exec_cmd`, `byte_valid` and `pause_in` do not start balancing: `run_ok` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| byte_valid | input | 1 | One-cycle strobe: a valid command byte was received |
| exec_cmd | input | 1 | One-cycle strobe: an execute command was received |
| bal_start | input | 1 | One-cycle strobe: a balance command begins executing |
| pause_in | input | 1 | Level of the external high drive on the status pin (pause request) |
| defeat | input | 1 | Watchdog defeat strap, 1 disables timeouts |
| run_ok | output | 1 | Permit to the balancer gating |
| wdt_pin | output | 1 | Modelled wired level of the open-drain status pin |

## Verification
The hardest case is a timeout that lands inside a pause. Reaching it requires entering running, then holding `pause_in` high for longer than the whole timeout window with no clear strobes, then releasing the pin and showing that the permit does not come back. The stimulus follows exactly that path. It then probes the boundary where `defeat` is dropped after a gap much longer than the window, where the timeout must be taken at once. The reference model counts the quiet cycles independently and compares both outputs in every cycle, so an off-by-one in the window shows up at the exact edge.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2,
        ST_HOLD    = 2'd3
    } cwd_state_e;

    typedef struct packed {
        cwd_state_e state;
    } cwd_ctrl_t;

endpackage

// File: rtl/cwd_timer.sv
module cwd_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clear,
    input  logic defeat,
    output logic expire
);
    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;
    logic at_last;

    always_comb begin
        r_d     = r_q;
        at_last = (r_q.cnt == LAST);
        expire  = active && !clear && !defeat && at_last;
        if (!active || clear) begin
            r_d.cnt = '0;
        end else if (!at_last) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/cwd_ctrl.sv
module cwd_ctrl
    import cwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bal_start,
    input  logic       exec_cmd,
    input  logic       pause_in,
    input  logic       expire,
    output cwd_state_e state_q,
    output logic       active
);
    cwd_ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE: begin
                if (bal_start) c_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (expire)        c_d.state = ST_EXPIRED;
                else if (pause_in) c_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (expire)         c_d.state = ST_EXPIRED;
                else if (!pause_in) c_d.state = ST_RUN;
            end
            ST_EXPIRED: begin
                if (exec_cmd) c_d.state = ST_RUN;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign state_q = c_q.state;
    assign active  = (c_q.state == ST_RUN) || (c_q.state == ST_HOLD);
endmodule

// File: rtl/cwd_watchdog.sv
module cwd_watchdog
    import cwd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_valid,
    input  logic exec_cmd,
    input  logic bal_start,
    input  logic pause_in,
    input  logic defeat,
    output logic run_ok,
    output logic wdt_pin
);
    cwd_state_e state_q;
    logic       active;
    logic       expire;
    logic       clear;

    assign clear = byte_valid || exec_cmd;

    cwd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .clear  (clear),
        .defeat (defeat),
        .expire (expire)
    );

    cwd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bal_start (bal_start),
        .exec_cmd  (exec_cmd),
        .pause_in  (pause_in),
        .expire    (expire),
        .state_q   (state_q),
        .active    (active)
    );

    // Pause masks the permit at once; the pin is pulled low while active,
    // and an external high drive wins over the pull-down.
    assign run_ok  = (state_q == ST_RUN) && !pause_in;
    assign wdt_pin = !active || pause_in;
endmodule

// File: rtl/cwd_watchdog_chk.sv
module cwd_watchdog_chk
    import cwd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic       exec_cmd,
    input logic       bal_start,
    input logic       pause_in,
    input logic       defeat,
    input logic       run_ok,
    input logic       wdt_pin,
    input cwd_state_e state_q
);
    localparam int GW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [GW-1:0] GLAST = GW'(TIMEOUT_CYC - 1);

    logic [GW-1:0] gap_q;
    logic          busy;

    assign busy = (state_q == ST_RUN) || (state_q == ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!busy || byte_valid || exec_cmd) begin
            gap_q <= '0;
        end else if (gap_q != GLAST) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bal_start) |=> (state_q == ST_RUN));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !bal_start) |=> (state_q == ST_IDLE));

    a_r3_expired_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED) |-> (wdt_pin && !run_ok));

    a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && gap_q != GLAST) |=> (state_q != ST_EXPIRED));

    a_r5_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && !exec_cmd) |=> (state_q == ST_EXPIRED));

    a_r6_pause_masks: assert property (@(posedge clk) disable iff (!rst_n)
        pause_in |-> (!run_ok && wdt_pin));

    a_r8_defeat: assert property (@(posedge clk) disable iff (!rst_n)
        (defeat && state_q != ST_EXPIRED) |=> (state_q != ST_EXPIRED));
endmodule

bind cwd_watchdog cwd_watchdog_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .exec_cmd   (exec_cmd),
    .bal_start  (bal_start),
    .pause_in   (pause_in),
    .defeat     (defeat),
    .run_ok     (run_ok),
    .wdt_pin    (wdt_pin),
    .state_q    (state_q)
);

// File: tb/cwd_watchdog_tb.sv
module cwd_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_valid = 1'b0;
    logic exec_cmd = 1'b0;
    logic bal_start = 1'b0;
    logic pause_in = 1'b0;
    logic defeat = 1'b0;
    logic run_ok;
    logic wdt_pin;

    int checks = 0;
    int errors = 0;

    // reference model: 0 idle, 1 running, 2 timed out, 3 paused
    int m_st = 0;
    int m_quiet = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cwd_watchdog #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .exec_cmd   (exec_cmd),
        .bal_start  (bal_start),
        .pause_in   (pause_in),
        .defeat     (defeat),
        .run_ok     (run_ok),
        .wdt_pin    (wdt_pin)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_quiet = 0;
        end else begin
            bit act, clr, tmo;
            act = (m_st == 1) || (m_st == 3);
            clr = byte_valid || exec_cmd;
            tmo = act && !clr && !defeat && (m_quiet >= TMO - 1);
            if (!act || clr) m_quiet = 0;
            else m_quiet = m_quiet + 1;
            case (m_st)
                0: if (bal_start) m_st = 1;
                1: if (tmo) m_st = 2; else if (pause_in) m_st = 3;
                3: if (tmo) m_st = 2; else if (!pause_in) m_st = 1;
                2: if (exec_cmd) m_st = 1;
                default: m_st = 0;
            endcase
        end
    end

    task automatic step(input string tag, input bit bv, input bit ex,
                        input bit bs, input bit pz, input bit df);
        bit exp_run, exp_pin;
        @(negedge clk);
        byte_valid = bv;
        exec_cmd   = ex;
        bal_start  = bs;
        pause_in   = pz;
        defeat     = df;
        #1;
        exp_run = (m_st == 1) && !pz;
        exp_pin = !((m_st == 1) || (m_st == 3)) || pz;
        checks++;
        if (run_ok !== exp_run || wdt_pin !== exp_pin) begin
            errors++;
            $display("FAIL %s: run_ok=%b wdt_pin=%b expected run_ok=%b wdt_pin=%b",
                     tag, run_ok, wdt_pin, exp_run, exp_pin);
        end
    endtask

    task automatic quiet(input string tag, input int n, input bit pz, input bit df);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 1'b0, pz, df);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        quiet("R1", 3, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet("R1", 2, 1'b0, 1'b0);

        // R9: idle ignores execute, bytes and pause
        step("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        quiet("R9", 3, 1'b1, 1'b0);
        quiet("R9", 2, 1'b0, 1'b0);

        // R2: start balancing
        step("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        quiet("R2", 3, 1'b0, 1'b0);

        // R4: bytes spaced below the window keep it running
        for (int k = 0; k < 6; k++) begin
            step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            quiet("R4", TMO - 2, 1'b0, 1'b0);
        end
        step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        quiet("R4", TMO - 1, 1'b0, 1'b0);

        // R3: silence across the full window times out
        quiet("R3", 4, 1'b0, 1'b0);

        // R5: only execute resumes
        step("R5", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R5", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        quiet("R5", 3, 1'b0, 1'b0);
        step("R5", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        quiet("R5", 3, 1'b0, 1'b0);

        // R6: short pause and resume
        step("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        quiet("R6", 3, 1'b1, 1'b0);
        quiet("R6", 3, 1'b0, 1'b0);
        step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: pause outlasting the window, release does not resume
        quiet("R7", TMO + 4, 1'b1, 1'b0);
        quiet("R7", 4, 1'b0, 1'b0);
        quiet("R7", 2, 1'b1, 1'b0);
        quiet("R7", 2, 1'b0, 1'b0);
        step("R7", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        quiet("R7", 2, 1'b0, 1'b0);

        // R8: defeat holds off timeout, dropping it times out at once
        quiet("R8", 3 * TMO, 1'b0, 1'b1);
        quiet("R8", 3, 1'b0, 1'b0);
        step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        quiet("R8", TMO + 2, 1'b0, 1'b0);

        // R1: reset mid-run returns to idle
        step("R1", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        quiet("R1", 2, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        quiet("R1", 2, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet("R1", 2, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule